// File: doc/BRIEF.md
# Per-Rank Memory Power State Controller

This block governs the power state of one memory rank. It watches the requests aimed at its rank and counts consecutive idle cycles. After a short idle stretch it drops the rank from active to standby. Once the idle time reaches a programmable break-even count, it drops the rank further to suspend. A request that arrives while the rank sits in a low-power state starts a wake-up. The rank stays stalled, with `ready` low, until that state's programmable wake latency has fully run out. The rank then returns to active and the request is served.

A membership input from the interleave configuration logic says whether the rank belongs to the set of ranks currently holding data. When that input is cleared, the rank goes to the zero-power offline state at once, even in the middle of a wake-up. Any request made while the rank is outside the set is refused with a one-cycle error pulse. The block also keeps one energy accumulator per power state. Each accumulator adds that state's power weight once for every cycle spent in the state. Higher logic can use these totals to judge the cost of the current interleave choice.

The DRAM command protocol, refresh and the link buffer are not part of this block.

Top module: `rank_pwr_ctrl`

## Requirements
- R1: After reset `pstate` is 2'b11 (offline), `ready` and `req_err` are 0, and all four energy accumulators read 0.
- R2: The state code is 2'b00 active, 2'b01 standby, 2'b10 suspend, 2'b11 offline, and `ready` is 1 exactly when `pstate` is 2'b00.
- R3: In active, with membership set, each clock edge without a request adds one to a saturating idle count. The rank enters standby at the edge where that count reaches `cfg_sby_idle`; a threshold of 0 acts as 1.
- R4: In standby, idle counting continues from the value reached in active, and the rank enters suspend at the edge where the count reaches `cfg_sus_idle`.
- R5: A request seen while active clears the idle count and keeps the rank active.
- R6: A request seen in standby, suspend or offline (membership set) keeps `pstate` unchanged and `ready` low for exactly L edges, where L is `cfg_wake_sby`, `cfg_wake_sus` or `cfg_wake_off` for that state (0 acts as 1). At the L-th edge the rank becomes active. Requests that arrive during a wake are absorbed by it.
- R7: While `rank_en` is 0, the rank is offline after the next edge from any state, and any wake-up in progress is abandoned.
- R8: `req_err` is 1 for the cycle following each edge at which `req_valid` is 1 and `rank_en` is 0, and 0 otherwise.
- R9: At each edge the accumulator for the current state, held in `energy[s*EW +: EW]` for state code s, grows by that state's weight (defaults 5300, 2000, 389, 0 for codes 0 to 3) and wraps modulo 2^EW.
- R10: With membership set, an offline rank leaves offline only through a request-started wake-up.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rank_en | input | 1 | Rank belongs to the active interleave set |
| req_valid | input | 1 | A request targets this rank (held until served) |
| cfg_sby_idle | input | IW | Idle cycles from active to standby |
| cfg_sus_idle | input | IW | Break-even idle count for suspend |
| cfg_wake_sby | input | WW | Wake latency from standby, cycles |
| cfg_wake_sus | input | WW | Wake latency from suspend, cycles |
| cfg_wake_off | input | WW | Wake latency from offline, cycles |
| pstate | output | 2 | Current power state code |
| ready | output | 1 | Rank can serve the request this cycle |
| req_err | output | 1 | Request refused because the rank is outside the set |
| energy | output | 4*EW | Per-state energy accumulators, state s at bits s*EW upward |

## Verification
Every result here is registered. State changes, `ready`, `req_err` and the accumulators therefore reflect the inputs sampled at the previous rising edge. A wake from a low state shows `ready` high only after the L-th edge following the first sampled request. The bench drives inputs on the falling edge and advances its own model of the requirements at the rising edge. It then compares every output at the next falling edge, so each expected value lines up with the edge that produced it. Directed cases also count the stalled falling edges of each wake and compare that count with L.

// File: rtl/rpc_pkg.sv
package rpc_pkg;
   typedef enum logic [1:0] {
      PS_ACT = 2'b00,
      PS_SBY = 2'b01,
      PS_SUS = 2'b10,
      PS_OFF = 2'b11
   } pstate_e;

   localparam int unsigned NUM_PS = 4;
endpackage

// File: rtl/rpc_idle_ctr.sv
module rpc_idle_ctr #(
   parameter int IW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   output logic [IW-1:0] cnt_q,
   output logic [IW-1:0] cnt_nx
);
   localparam logic [IW-1:0] CNT_MAX = '1;

   // saturating count of consecutive idle edges
   always_comb begin
      if (clr)                  cnt_nx = '0;
      else if (cnt_q == CNT_MAX) cnt_nx = CNT_MAX;
      else                      cnt_nx = cnt_q + IW'(1);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= cnt_nx;
   end
endmodule

// File: rtl/rpc_wake_tmr.sv
module rpc_wake_tmr #(
   parameter int WW = 12
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          abort,
   input  logic          load,
   input  logic [WW-1:0] lat,
   output logic          busy,
   output logic          done
);
   logic [WW-1:0] cnt_q;

   assign busy = (cnt_q != '0);
   assign done = (cnt_q == WW'(1));

   always_ff @(posedge clk) begin
      if (!rst_n)      cnt_q <= '0;
      else if (abort)  cnt_q <= '0;
      else if (load)   cnt_q <= (lat == '0) ? WW'(1) : lat;
      else if (busy)   cnt_q <= cnt_q - WW'(1);
   end
endmodule

// File: rtl/rpc_energy_acc.sv
module rpc_energy_acc #(
   parameter int          EW    = 32,
   parameter int unsigned W_ACT = 5300,
   parameter int unsigned W_SBY = 2000,
   parameter int unsigned W_SUS = 389,
   parameter int unsigned W_OFF = 0
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [1:0]                   st,
   output logic [rpc_pkg::NUM_PS*EW-1:0] acc_o
);
   localparam int unsigned NPS = rpc_pkg::NUM_PS;
   localparam int unsigned WT [NPS] = '{W_ACT, W_SBY, W_SUS, W_OFF};

   for (genvar s = 0; s < NPS; s++) begin : g_acc
      logic [EW-1:0] acc_q;
      if (WT[s] == 0) begin : g_zero
         // a zero-weight state never accumulates
         always_ff @(posedge clk) acc_q <= '0;
      end else begin : g_add
         always_ff @(posedge clk) begin
            if (!rst_n)              acc_q <= '0;
            else if (st == 2'(s))    acc_q <= acc_q + EW'(WT[s]);
         end
      end
      assign acc_o[s*EW +: EW] = acc_q;
   end
endmodule

// File: rtl/rank_pwr_ctrl.sv
module rank_pwr_ctrl #(
   parameter int          IW    = 16,
   parameter int          WW    = 12,
   parameter int          EW    = 32,
   parameter int unsigned W_ACT = 5300,
   parameter int unsigned W_SBY = 2000,
   parameter int unsigned W_SUS = 389,
   parameter int unsigned W_OFF = 0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          rank_en,
   input  logic          req_valid,
   input  logic [IW-1:0] cfg_sby_idle,
   input  logic [IW-1:0] cfg_sus_idle,
   input  logic [WW-1:0] cfg_wake_sby,
   input  logic [WW-1:0] cfg_wake_sus,
   input  logic [WW-1:0] cfg_wake_off,
   output logic [1:0]    pstate,
   output logic          ready,
   output logic          req_err,
   output logic [4*EW-1:0] energy
);
   import rpc_pkg::*;

   if (IW < 2)  begin : g_bad_iw $error("IW must be at least 2"); end
   if (WW < 2)  begin : g_bad_ww $error("WW must be at least 2"); end
   if (EW < 16) begin : g_bad_ew $error("EW must be at least 16"); end

   pstate_e       st_q, st_d;
   logic [IW-1:0] idle_q, idle_nx;
   logic          idle_clr;
   logic          wk_busy, wk_done, wk_start;
   logic [WW-1:0] wk_lat;
   logic          err_q;

   // idle counting only in the two shallow states with no wake pending
   assign idle_clr = req_valid || wk_busy || !rank_en ||
                     !((st_q == PS_ACT) || (st_q == PS_SBY));

   rpc_idle_ctr #(.IW(IW)) u_idle (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (idle_clr),
      .cnt_q  (idle_q),
      .cnt_nx (idle_nx)
   );

   assign wk_start = rank_en && req_valid && (st_q != PS_ACT) && !wk_busy;

   always_comb begin
      unique case (st_q)
         PS_SUS:  wk_lat = cfg_wake_sus;
         PS_OFF:  wk_lat = cfg_wake_off;
         default: wk_lat = cfg_wake_sby;
      endcase
   end

   rpc_wake_tmr #(.WW(WW)) u_wake (
      .clk   (clk),
      .rst_n (rst_n),
      .abort (!rank_en),
      .load  (wk_start),
      .lat   (wk_lat),
      .busy  (wk_busy),
      .done  (wk_done)
   );

   always_comb begin
      st_d = st_q;
      if (!rank_en) begin
         st_d = PS_OFF;
      end else if (wk_done) begin
         st_d = PS_ACT;
      end else if (!req_valid && !wk_busy) begin
         unique case (st_q)
            PS_ACT:  if (idle_nx >= cfg_sby_idle) st_d = PS_SBY;
            PS_SBY:  if (idle_nx >= cfg_sus_idle) st_d = PS_SUS;
            default: st_d = st_q;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q  <= PS_OFF;
         err_q <= 1'b0;
      end else begin
         st_q  <= st_d;
         err_q <= req_valid && !rank_en;
      end
   end

   rpc_energy_acc #(
      .EW(EW), .W_ACT(W_ACT), .W_SBY(W_SBY), .W_SUS(W_SUS), .W_OFF(W_OFF)
   ) u_energy (
      .clk   (clk),
      .rst_n (rst_n),
      .st    (st_q),
      .acc_o (energy)
   );

   assign pstate  = st_q;
   assign ready   = (st_q == PS_ACT);
   assign req_err = err_q;
endmodule

// File: rtl/rpc_chk.sv
module rpc_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       rank_en,
   input logic       req_valid,
   input logic [1:0] pstate,
   input logic       req_err
);
   logic past_ok;

   always_ff @(posedge clk) begin
      if (!rst_n) past_ok <= 1'b0;
      else        past_ok <= 1'b1;
   end

   AST_OFF_ON_DISABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && !$past(rank_en)) |-> (pstate == 2'b11)); // R7

   AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      req_err |-> (past_ok && $past(req_valid) && !$past(rank_en))); // R8

   AST_WAKE_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && ($past(pstate) != 2'b00) && (pstate == 2'b00)) |-> $past(rank_en)); // R6

   AST_ACT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && ($past(pstate) == 2'b00)) |-> (pstate != 2'b10)); // R3

   AST_OFF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && ($past(pstate) == 2'b11) && $past(rank_en))
         |-> ((pstate == 2'b11) || (pstate == 2'b00))); // R10
endmodule

bind rank_pwr_ctrl rpc_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .rank_en   (rank_en),
   .req_valid (req_valid),
   .pstate    (pstate),
   .req_err   (req_err)
);

// File: tb/tb_rank_pwr_ctrl.sv
`timescale 1ns/1ps
module tb_rank_pwr_ctrl;
   localparam int IW = 8;
   localparam int WW = 6;
   localparam int EW = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          rank_en = 1'b0;
   logic          req_valid = 1'b0;
   logic [IW-1:0] cfg_sby_idle = '0;
   logic [IW-1:0] cfg_sus_idle = '0;
   logic [WW-1:0] cfg_wake_sby = '0;
   logic [WW-1:0] cfg_wake_sus = '0;
   logic [WW-1:0] cfg_wake_off = '0;
   logic [1:0]    pstate;
   logic          ready;
   logic          req_err;
   logic [4*EW-1:0] energy;

   always #2 clk = ~clk;

   rank_pwr_ctrl #(.IW(IW), .WW(WW), .EW(EW)) dut (
      .clk(clk), .rst_n(rst_n), .rank_en(rank_en), .req_valid(req_valid),
      .cfg_sby_idle(cfg_sby_idle), .cfg_sus_idle(cfg_sus_idle),
      .cfg_wake_sby(cfg_wake_sby), .cfg_wake_sus(cfg_wake_sus),
      .cfg_wake_off(cfg_wake_off),
      .pstate(pstate), .ready(ready), .req_err(req_err), .energy(energy)
   );

   int n_chk = 0;
   int n_fail = 0;
   int cyc = 0;
   string cur_tag = "R1";

   // ---------------- requirement model ----------------
   int          m_st = 3;
   int          m_idle = 0;
   int          m_wk = 0;
   logic        m_err = 1'b0;
   logic [31:0] m_e [4];

   function automatic logic [31:0] weight(input int s);
      case (s)
         0: return 32'd5300;
         1: return 32'd2000;
         2: return 32'd389;
         default: return 32'd0;
      endcase
   endfunction

   function automatic int eff(input int v);
      return (v == 0) ? 1 : v;
   endfunction

   always @(posedge clk) begin
      cyc = cyc + 1;
      if (!rst_n) begin
         m_st = 3; m_idle = 0; m_wk = 0; m_err = 1'b0;
         for (int s = 0; s < 4; s++) m_e[s] = 32'd0;
      end else begin
         m_e[m_st] = m_e[m_st] + weight(m_st);
         m_err = req_valid && !rank_en;
         if (!rank_en) begin
            m_st = 3; m_wk = 0; m_idle = 0;
         end else if (m_wk != 0) begin
            m_wk = m_wk - 1;
            if (m_wk == 0) m_st = 0;
            m_idle = 0;
         end else if (req_valid) begin
            m_idle = 0;
            if (m_st == 1)      m_wk = eff(int'(cfg_wake_sby));
            else if (m_st == 2) m_wk = eff(int'(cfg_wake_sus));
            else if (m_st == 3) m_wk = eff(int'(cfg_wake_off));
         end else if (m_st <= 1) begin
            if (m_idle < 255) m_idle = m_idle + 1;
            if (m_st == 0 && m_idle >= eff(int'(cfg_sby_idle)))
               m_st = 1;
            else if (m_st == 1 && m_idle >= int'(cfg_sus_idle))
               m_st = 2;
         end else begin
            m_idle = 0;
         end
      end
   end

   task automatic check(input string tag, input longint act, input longint exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s cycle %0d: actual %0d expected %0d", tag, cyc, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
      check(cur_tag, pstate, m_st);
      check("R2", ready, (m_st == 0));
      check("R8", req_err, m_err);
      for (int s = 0; s < 4; s++) check("R9", energy[s*EW +: EW], m_e[s]);
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) tick();
   endtask

   task automatic wake_count(input string tag, input int exp);
      int n = 0;
      req_valid = 1'b1;
      tick();
      while (!ready && n < 100) begin
         n++;
         tick();
      end
      req_valid = 1'b0;
      check(tag, n, exp);
   endtask

   // watchdog
   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      void'($urandom(32'd2718));
      // R1 reset state
      ticks(3);
      check("R1", pstate, 3);
      check("R1", ready, 0);
      check("R1", req_err, 0);
      check("R1", energy, 0);
      rst_n = 1'b1;
      rank_en = 1'b1;
      cfg_sby_idle = 8'd4; cfg_sus_idle = 8'd9;
      cfg_wake_sby = 6'd3; cfg_wake_sus = 6'd5; cfg_wake_off = 6'd7;

      // R10 offline holds without a request
      cur_tag = "R10";
      ticks(20);
      check("R10", pstate, 3);

      // R6 wake from offline
      cur_tag = "R6";
      wake_count("R6", 7);
      check("R6", pstate, 0);

      // R5 requests keep rank active
      cur_tag = "R5";
      req_valid = 1'b1;
      ticks(12);
      check("R5", pstate, 0);
      req_valid = 1'b0;

      // R3 standby after 4 idle edges
      cur_tag = "R3";
      ticks(3);
      check("R3", pstate, 0);
      tick();
      check("R3", pstate, 1);

      // R6 wake from standby
      cur_tag = "R6";
      wake_count("R6", 3);

      // R4 suspend at break-even count 9
      cur_tag = "R4";
      ticks(8);
      check("R4", pstate, 1);
      tick();
      check("R4", pstate, 2);

      // R6 wake from suspend, and zero latency acting as 1
      cur_tag = "R6";
      wake_count("R6", 5);
      cfg_wake_sby = 6'd0;
      ticks(4);
      check("R6", pstate, 1);
      wake_count("R6", 1);

      // R7 / R8 membership drop during a wake
      cur_tag = "R7";
      ticks(12);
      check("R7", pstate, 2);
      req_valid = 1'b1;
      ticks(2);
      rank_en = 1'b0;
      tick();
      check("R7", pstate, 3);
      check("R8", req_err, 1);
      req_valid = 1'b0;
      tick();
      check("R8", req_err, 0);
      rank_en = 1'b1;
      cur_tag = "R10";
      ticks(30);
      check("R10", pstate, 3);

      // constrained random episodes
      cur_tag = "R6";
      for (int ep = 0; ep < 60; ep++) begin
         int p;
         cfg_sby_idle = IW'($urandom_range(0, 6));
         cfg_sus_idle = IW'($urandom_range(0, 15));
         cfg_wake_sby = WW'($urandom_range(0, 4));
         cfg_wake_sus = WW'($urandom_range(0, 8));
         cfg_wake_off = WW'($urandom_range(0, 12));
         case ($urandom_range(0, 2))
            0: p = 3;
            1: p = 15;
            default: p = 50;
         endcase
         for (int c = 0; c < 80; c++) begin
            rank_en   = ($urandom_range(0, 24) != 0);
            req_valid = ($urandom_range(0, 99) < p);
            tick();
         end
      end

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule